// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block sits on the receive byte stream of an Ethernet port while the rest of the device is powered down. It hunts every frame for a wake pattern: a run of all-ones bytes followed by the local node address repeated a fixed number of times, back to back. The pattern may begin at any byte of the frame, and arbitrary filler bytes may separate the all-ones run from the first address copy.

A match is only noted while the frame streams past. The wake is committed at the end-of-frame beat, and only if four conditions hold: the frame checksum was good, the upstream filter accepted the destination address, and both the magic-wake enable and the power-management-event enable are set. A committed wake sets a sticky event status flag. The event request output follows that flag whenever the event enable is set. Software clears the flag by pulsing a write-one-to-clear strobe.

Top module: `magic_wake_detector`

## Requirements
- R1: A frame holding SYNC_LEN (6) bytes of 8'hFF, then REPEATS (16) consecutive copies of the node address, sets `pme_status` at the clock edge that samples its end-of-frame beat. Each copy is sent with node_addr[47:40] first and node_addr[7:0] last.
- R2: The pattern is found whatever its byte offset inside the frame, including far past the 14-byte header.
- R3: Any number of non-matching filler bytes, including none, between the all-ones run and the first address copy still gives a match.
- R4: An all-ones run longer than SYNC_LEN keeps the matcher synchronised, so seven or more 8'hFF bytes before the copies still match.
- R5: No wake is committed when `rx_crc_ok` is 0 on the end-of-frame beat, even if the pattern matched.
- R6: No wake is committed when `rx_addr_ok` is 0 on the end-of-frame beat.
- R7: A wake needs `magic_en`=1 and `pme_en`=1. `pme_req` is the registered AND of the next status value and `pme_en`, so clearing `pme_en` drops `pme_req` one edge later while `pme_status` is kept.
- R8: A byte that breaks the address copies returns the matcher to hunting for all-ones bytes. That same byte is re-examined, so a breaking 8'hFF counts as the first byte of a new run.
- R9: Matcher state clears on the start-of-frame beat. A pattern split across two frames never wakes.
- R10: `pme_status` is sticky until a `pme_status_w1c` pulse clears it, and clearing also drops `pme_req`. A wake committed on the same edge as a clear wins.
- R11: After reset `pme_status` and `pme_req` are 0. Cycles with `rx_valid` low are ignored by the matcher.
- R12: A frame with fewer than REPEATS copies, or fewer than SYNC_LEN all-ones bytes in front of them, does not wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Byte strobe for rx_data |
| rx_sof | input | 1 | Marks the first byte of a frame (with rx_valid) |
| rx_eof | input | 1 | Marks the last byte of a frame (with rx_valid) |
| rx_data | input | 8 | Received byte |
| rx_crc_ok | input | 1 | Frame checksum good, sampled on the end-of-frame beat |
| rx_addr_ok | input | 1 | Destination address accepted, sampled on the end-of-frame beat |
| node_addr | input | 48 | Local node address |
| magic_en | input | 1 | Magic-wake enable |
| pme_en | input | 1 | Power-management-event enable |
| pme_status_w1c | input | 1 | Write-one-to-clear pulse for pme_status |
| pme_status | output | 1 | Sticky wake event status |
| pme_req | output | 1 | Wake request, status gated by pme_en |

## Verification
The bench builds the block with its default values: six all-ones sync bytes, sixteen copies and a six-byte address. This makes the full-length pattern, the extra-long run and the short-by-one cases exercisable at their real sizes. Each frame is about 120 bytes, so dozens of frames fit in the run, including frames that place the pattern at odd offsets, put idle cycles inside a frame, or break the copies with an all-ones byte. The same setting covers the last-copy boundary, where fifteen copies must fail and sixteen must pass.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {
    S_HUNT  = 2'd0,
    S_ARMED = 2'd1,
    S_ADDR  = 2'd2
  } match_st_t;
endpackage

// File: rtl/mpd_byte_matcher.sv
module mpd_byte_matcher
  import mpd_pkg::*;
#(
  parameter int SYNC_LEN   = 6,
  parameter int REPEATS    = 16,
  parameter int ADDR_BYTES = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         beat,
  input  logic                         sof,
  input  logic [BYTE_W-1:0]            data,
  input  logic [ADDR_BYTES*BYTE_W-1:0] node_addr,
  output logic                         match_now
);
  localparam int FFW = $clog2(SYNC_LEN + 1);
  localparam int IW  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int RW  = (REPEATS > 1) ? $clog2(REPEATS) : 1;
  localparam logic [FFW-1:0] FF_FULL  = FFW'(SYNC_LEN);
  localparam logic [IW-1:0]  IDX_LAST = IW'(ADDR_BYTES - 1);
  localparam logic [RW-1:0]  REP_LAST = RW'(REPEATS - 1);

  logic [BYTE_W-1:0] addr_b [ADDR_BYTES];
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign addr_b[g] = node_addr[(ADDR_BYTES-1-g)*BYTE_W +: BYTE_W];
  end

  match_st_t      st_q, st_b, st_d;
  logic [FFW-1:0] ff_q, ff_b, ff_d;
  logic [IW-1:0]  idx_q, idx_b, idx_d;
  logic [RW-1:0]  rep_q, rep_b, rep_d;
  logic           found_q, found_b, found_d, hit;
  logic           is_ff;

  assign is_ff = (data == '1);

  always_comb begin
    // start-of-frame: process this byte from a clean state
    st_b    = sof ? S_HUNT : st_q;
    ff_b    = sof ? '0 : ff_q;
    idx_b   = sof ? '0 : idx_q;
    rep_b   = sof ? '0 : rep_q;
    found_b = sof ? 1'b0 : found_q;
    st_d = st_b; ff_d = ff_b; idx_d = idx_b; rep_d = rep_b;
    hit  = 1'b0;
    unique case (st_b)
      S_HUNT: begin
        if (is_ff) begin
          ff_d = ff_b + 1'b1;
          if (ff_b == FF_FULL - 1'b1) st_d = S_ARMED;
        end else begin
          ff_d = '0;
        end
      end
      S_ARMED: begin
        // all-ones and filler bytes both keep the sync
        if (data == addr_b[0]) begin
          st_d  = S_ADDR;
          idx_d = IW'(1);
          rep_d = '0;
        end
      end
      S_ADDR: begin
        if (data == addr_b[idx_b]) begin
          if (idx_b == IDX_LAST) begin
            idx_d = '0;
            if (rep_b == REP_LAST) begin
              hit   = 1'b1;
              st_d  = S_HUNT;
              ff_d  = '0;
              rep_d = '0;
            end else begin
              rep_d = rep_b + 1'b1;
            end
          end else begin
            idx_d = idx_b + 1'b1;
          end
        end else begin
          // broken copy: re-examine this byte as a new sync start
          st_d  = S_HUNT;
          idx_d = '0;
          rep_d = '0;
          ff_d  = is_ff ? FFW'(1) : '0;
        end
      end
      default: st_d = S_HUNT;
    endcase
    found_d = found_b | hit;
  end

  assign match_now = beat & found_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_HUNT; ff_q <= '0; idx_q <= '0; rep_q <= '0; found_q <= 1'b0;
    end else if (beat) begin
      st_q <= st_d; ff_q <= ff_d; idx_q <= idx_d; rep_q <= rep_d; found_q <= found_d;
    end
  end

  p_ff_bounded_r4: assert property (@(posedge clk) disable iff (rst)
    ff_q <= FF_FULL);
  p_sof_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (beat && sof && data != '1) |=> (st_q == S_HUNT && ff_q == '0 && !found_q));
  p_idle_holds_r11: assert property (@(posedge clk) disable iff (rst)
    !beat |=> ($stable(st_q) && $stable(found_q) && $stable(ff_q)));
  p_found_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (found_q && !(beat && sof)) |=> found_q);
endmodule

// File: rtl/mpd_wake_commit.sv
module mpd_wake_commit (
  input  logic clk,
  input  logic rst,
  input  logic eof_beat,
  input  logic matched,
  input  logic crc_ok,
  input  logic addr_ok,
  input  logic magic_en,
  input  logic pme_en,
  input  logic status_w1c,
  output logic pme_status,
  output logic pme_req
);
  logic wake, status_d;

  assign wake     = eof_beat & matched & crc_ok & addr_ok & magic_en & pme_en;
  assign status_d = wake ? 1'b1 : (status_w1c ? 1'b0 : pme_status);

  always_ff @(posedge clk) begin
    if (rst) begin
      pme_status <= 1'b0;
      pme_req    <= 1'b0;
    end else begin
      pme_status <= status_d;
      pme_req    <= status_d & pme_en;
    end
  end

  p_crc_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (eof_beat && !crc_ok && !pme_status && !status_w1c) |=> !pme_status);
  p_addr_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (eof_beat && !addr_ok && !pme_status) |=> !pme_status);
  p_req_needs_status_r7: assert property (@(posedge clk) disable iff (rst)
    pme_req |-> pme_status);
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (status_w1c && !eof_beat) |=> (!pme_status && !pme_req));
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (pme_status && !status_w1c) |=> pme_status);
endmodule

// File: rtl/magic_wake_detector.sv
module magic_wake_detector
  import mpd_pkg::*;
#(
  parameter int SYNC_LEN   = 6,
  parameter int REPEATS    = 16,
  parameter int ADDR_BYTES = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rx_valid,
  input  logic                         rx_sof,
  input  logic                         rx_eof,
  input  logic [BYTE_W-1:0]            rx_data,
  input  logic                         rx_crc_ok,
  input  logic                         rx_addr_ok,
  input  logic [ADDR_BYTES*BYTE_W-1:0] node_addr,
  input  logic                         magic_en,
  input  logic                         pme_en,
  input  logic                         pme_status_w1c,
  output logic                         pme_status,
  output logic                         pme_req
);
  logic match_now;

  mpd_byte_matcher #(
    .SYNC_LEN(SYNC_LEN), .REPEATS(REPEATS), .ADDR_BYTES(ADDR_BYTES)
  ) u_match (
    .clk(clk), .rst(rst), .beat(rx_valid), .sof(rx_sof), .data(rx_data),
    .node_addr(node_addr), .match_now(match_now)
  );

  mpd_wake_commit u_commit (
    .clk(clk), .rst(rst), .eof_beat(rx_valid & rx_eof), .matched(match_now),
    .crc_ok(rx_crc_ok), .addr_ok(rx_addr_ok), .magic_en(magic_en),
    .pme_en(pme_en), .status_w1c(pme_status_w1c),
    .pme_status(pme_status), .pme_req(pme_req)
  );
endmodule

// File: tb/magic_wake_detector_bench.sv
`timescale 1ns/1ps
module magic_wake_detector_bench;
  logic clk = 0, rst = 1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc_ok = 0, rx_addr_ok = 0;
  logic [7:0] rx_data = 0;
  logic [47:0] node_addr = 48'h02_1A_3C_4D_5E_6F;
  logic magic_en = 1, pme_en = 1, pme_status_w1c = 0;
  logic pme_status, pme_req;

  magic_wake_detector u_magic_wake_detector (.*);

  always #2.5 clk = ~clk;

  typedef struct { logic st; logic rq; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  logic exp_status = 0;
  byte unsigned fr[$];

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // frame building helpers
  task automatic put_hdr();
    for (int i = 0; i < 6; i++) fr.push_back(node_addr[47-8*i -: 8]);
    for (int i = 0; i < 6; i++) fr.push_back(8'h10 + 8'(i));
    fr.push_back(8'h08); fr.push_back(8'h00);
  endtask
  task automatic put_fill(input int n, input byte unsigned v);
    for (int i = 0; i < n; i++) fr.push_back(v);
  endtask
  task automatic put_copies(input int n);
    for (int c = 0; c < n; c++)
      for (int i = 0; i < 6; i++) fr.push_back(node_addr[47-8*i -: 8]);
  endtask

  task automatic send(input string tag, input logic matched, input logic crc,
                      input logic aok, input int gap, input logic clr_at_eof);
    exp_t e;
    logic wake = matched & crc & aok & magic_en & pme_en;
    exp_status = wake ? 1'b1 : (clr_at_eof ? 1'b0 : exp_status);
    e.st = exp_status; e.rq = exp_status & pme_en; e.tag = tag;
    sb.push_back(e);
    for (int i = 0; i < fr.size(); i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fr[i];
      rx_sof = (i == 0); rx_eof = (i == fr.size() - 1);
      rx_crc_ok = crc; rx_addr_ok = aok;
      pme_status_w1c = clr_at_eof && (i == fr.size() - 1);
      if (gap != 0 && (i % gap) == gap - 1 && i != fr.size() - 1) begin
        @(negedge clk);
        rx_valid = 0; rx_data = 8'hFF; rx_sof = 0; rx_eof = 0;
      end
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; pme_status_w1c = 0;
    rx_crc_ok = 0; rx_addr_ok = 0;
    fr.delete();
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_status(input string tag);
    @(negedge clk); pme_status_w1c = 1;
    @(negedge clk); pme_status_w1c = 0;
    exp_status = 0;
    check(tag, pme_status, 1'b0, "status after clear");
    check(tag, pme_req, 1'b0, "req after clear");
  endtask

  // monitor: compare at the negedge after each end-of-frame edge
  initial begin
    forever begin
      @(posedge clk);
      if (!rst && rx_valid && rx_eof) begin
        exp_t e;
        @(negedge clk);
        e = sb.pop_front();
        check(e.tag, pme_status, e.st, "pme_status");
        check(e.tag, pme_req, e.rq, "pme_req");
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R11", pme_status, 1'b0, "reset status");
    check("R11", pme_req, 1'b0, "reset req");

    // R1 basic pattern right after the header
    put_hdr(); put_fill(6, 8'hFF); put_copies(16); put_fill(4, 8'h00);
    send("R1", 1, 1, 1, 0, 0);
    clear_status("R10");

    // R2 odd offset, R3 filler between run and copies
    put_hdr(); put_fill(37, 8'h5A); put_fill(6, 8'hFF); put_fill(5, 8'hC3);
    put_copies(16);
    send("R2_R3", 1, 1, 1, 0, 0);
    clear_status("R10");

    // R4 longer all-ones run
    put_hdr(); put_fill(9, 8'hFF); put_copies(16);
    send("R4", 1, 1, 1, 0, 0);
    clear_status("R10");

    // R5 checksum bad
    put_hdr(); put_fill(6, 8'hFF); put_copies(16);
    send("R5", 1, 0, 1, 0, 0);

    // R6 address rejected
    put_hdr(); put_fill(6, 8'hFF); put_copies(16);
    send("R6", 1, 1, 0, 0, 0);

    // R7 enables
    magic_en = 0;
    put_hdr(); put_fill(6, 8'hFF); put_copies(16);
    send("R7", 1, 1, 1, 0, 0);
    magic_en = 1; pme_en = 0;
    put_hdr(); put_fill(6, 8'hFF); put_copies(16);
    send("R7", 1, 1, 1, 0, 0);
    pme_en = 1;

    // R12 fifteen copies, five all-ones bytes
    put_hdr(); put_fill(6, 8'hFF); put_copies(15); put_fill(3, 8'h11);
    send("R12", 0, 1, 1, 0, 0);
    put_hdr(); put_fill(5, 8'hFF); put_copies(16);
    send("R12", 0, 1, 1, 0, 0);

    // R8 broken copy by an all-ones byte that starts the new run
    put_hdr(); put_fill(6, 8'hFF); put_copies(3); put_fill(6, 8'hFF); put_copies(16);
    send("R8", 1, 1, 1, 0, 0);
    clear_status("R10");

    // R9 pattern split across two frames
    put_hdr(); put_fill(6, 8'hFF); put_copies(8);
    send("R9", 0, 1, 1, 0, 0);
    put_copies(8); put_fill(2, 8'h33);
    send("R9", 0, 1, 1, 0, 0);

    // R11 idle cycles inside a frame
    put_hdr(); put_fill(6, 8'hFF); put_copies(16);
    send("R11", 1, 1, 1, 3, 0);

    // R10 sticky over a non-matching frame, then R7 req follows pme_en
    put_hdr(); put_fill(20, 8'h44);
    send("R10", 0, 1, 1, 0, 0);
    @(negedge clk); pme_en = 0;
    @(negedge clk);
    check("R7", pme_status, 1'b1, "status kept with pme_en low");
    check("R7", pme_req, 1'b0, "req with pme_en low");
    pme_en = 1;
    @(negedge clk);
    check("R7", pme_req, 1'b1, "req restored");
    clear_status("R10");

    // R10 wake on the same edge as a clear wins
    put_hdr(); put_fill(6, 8'hFF); put_copies(16);
    send("R10", 1, 1, 1, 0, 1);
    clear_status("R10");

    repeat (4) @(negedge clk);
    check("R1", 1'(sb.size() == 0), 1'b1, "scoreboard drained");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule